// File: doc/BRIEF.md
# Fully Unrolled AES-128 Encryption Pipeline

This block encrypts 128-bit blocks with AES-128 at a sustained rate of one block per clock. All ten cipher rounds are laid out as separate combinational stages, and a single register bank sits after the initial key whitening and after each round. No round has a register inside it. A block presented with `in_valid` high is captured on a rising edge. Its ciphertext leaves the last register bank eleven edges later, together with a raised `out_valid`.

The expanded key schedule is generated outside the block and supplied on a flat bus as eleven 128-bit round keys. Each stage reads its own slice of that bus while it computes. The key bus must therefore stay unchanged while any block is in flight; a new key is loaded once the pipeline has drained. A valid bit travels next to each state word. Stage registers load only when the valid bit beside them is set, so idle cycles leave the data registers untouched.

Top module: `aes128_pipe_enc`

## Requirements
- R1: With key 000102…0e0f and plaintext 00112233…eeff the ciphertext is 69c4e0d86a7b0430d8cdb78070b4c55a. This exercises the ten-round structure: rounds 1 to 9 apply S-box substitution, row rotation, column mixing and key XOR, and round 10 omits the column mixing.
- R2: A block captured on edge N appears on `ciphertext` with `out_valid` high directly after edge N+10. Directly after edge N+9, `out_valid` is still low for that block.
- R3: Blocks presented on consecutive cycles leave on consecutive cycles. Each one carries its own correct ciphertext, and the `out_valid` sequence equals the `in_valid` sequence delayed by eleven edges.
- R4: A rising edge with `rst` high clears every valid bit and zeroes `ciphertext`. No block that was in flight at that reset ever appears on the output.
- R5: A cycle in which `out_valid` is low leaves `ciphertext` unchanged from its previous value. After reset, that value is zero.
- R6: With an all-zero key and an all-zero plaintext the ciphertext is 66e94bd4ef8a2c3b884cfa59ca342b2e. This exercises the substitution table, including its entry for zero.
- R7: Bytes with the most significant bit set are doubled in GF(2^8) by a left shift followed by XOR with 0x1B. Tripling is doubling XOR the byte itself. This is checked with states full of 0x80 and 0xFF bytes.
- R8: Byte order: byte 0 of a block is bits [127:120] and byte i is bits [127-8i:120-8i]. Byte i sits in column i/4, row i%4. Row r is rotated left by r byte positions. The key 2b7e1516…09cf4f3c with plaintext 3243f6a8…e0370734 gives 3925841d02dc09fbdc118597196a0b32.
- R9: Round key k occupies `round_keys[128k+127:128k]`, with the same byte order as R8. Key 0 is XORed into the plaintext before round 1. A new key schedule loaded after the pipeline drains takes effect for the blocks that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Plaintext on this cycle is to be encrypted |
| plaintext | input | 128 | Input block, byte 0 in the top bits |
| round_keys | input | 1408 | Eleven round keys, key k in bits [128k+127:128k] |
| out_valid | output | 1 | `ciphertext` holds a finished block |
| ciphertext | output | 128 | Encrypted block, registered |

## Verification
The bench first aims at the round structure with three known vectors. A final round that still mixed columns, a swapped byte order, or a wrong zero entry in the S-box each yields a totally different ciphertext. It counts edges around a lone block, so a stage that is missing or duplicated moves `out_valid` by one cycle. Long back-to-back bursts and bursts with holes compare every output against a behavioural model. A valid bit that is dropped or shifted, or a state register that does not hold while idle, shows up as a mismatch on the exact cycle. A reset in the middle of a burst must swallow every block in flight; a valid chain left partly uncleared would emit ghost outputs afterwards.

// File: rtl/aes_pipe_pkg.sv
package aes_pipe_pkg;

  localparam int BYTE_W   = 8;
  localparam int BLK_W    = 128;
  localparam int NBYTES   = BLK_W / BYTE_W;
  localparam int NROWS    = 4;
  localparam int NCOLS    = NBYTES / NROWS;
  localparam int COL_W    = NROWS * BYTE_W;
  localparam int ROUNDS   = 10;
  localparam int STAGES   = ROUNDS + 1;
  localparam int KEYS_W   = STAGES * BLK_W;
  localparam int SBOX_N   = 1 << BYTE_W;
  localparam logic [BYTE_W-1:0] GF_POLY = 8'h1b;
  localparam logic [BYTE_W-1:0] AFF_C   = 8'h63;

  // multiply by x modulo the field polynomial
  function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] b);
    return {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? GF_POLY : '0);
  endfunction

  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  // inverse as a^254; zero maps to zero
  function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] a);
    logic [BYTE_W-1:0] r;
    r = a;
    for (int i = 0; i < 6; i++) r = gf_mul(gf_mul(r, r), a);
    return gf_mul(r, r);
  endfunction

  function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] b, input int n);
    return (b << n) | (b >> (BYTE_W - n));
  endfunction

  function automatic logic [BYTE_W-1:0] sbox_calc(input logic [BYTE_W-1:0] a);
    logic [BYTE_W-1:0] v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ AFF_C;
  endfunction

  // whole substitution table, entry v at bits [8v+7:8v]
  function automatic logic [SBOX_N*BYTE_W-1:0] sbox_table();
    logic [SBOX_N*BYTE_W-1:0] t;
    for (int v = 0; v < SBOX_N; v++) t[v*BYTE_W +: BYTE_W] = sbox_calc(BYTE_W'(v));
    return t;
  endfunction

  localparam logic [SBOX_N*BYTE_W-1:0] SBOX_ROM = sbox_table();

  // bit offset (low end) of byte i inside a block, byte 0 at the top
  function automatic int byte_lsb(input int i);
    return BLK_W - BYTE_W * (i + 1);
  endfunction

endpackage

// File: rtl/aes_sbox_bank.sv
module aes_sbox_bank
  import aes_pipe_pkg::*;
(
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout
);

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic [BYTE_W-1:0] idx;
    assign idx = din[byte_lsb(i) +: BYTE_W];
    assign dout[byte_lsb(i) +: BYTE_W] = SBOX_ROM[int'(idx)*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/aes_col_mix.sv
module aes_col_mix
  import aes_pipe_pkg::*;
(
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o
);

  logic [BYTE_W-1:0] a  [NROWS];
  logic [BYTE_W-1:0] a2 [NROWS];
  logic [BYTE_W-1:0] a3 [NROWS];

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    assign a[r]  = col_i[COL_W-BYTE_W*(r+1) +: BYTE_W];
    assign a2[r] = gf_dbl(a[r]);
    assign a3[r] = a2[r] ^ a[r];
    // circulant row: 2 on the diagonal, 3 right of it, 1 elsewhere
    assign col_o[COL_W-BYTE_W*(r+1) +: BYTE_W] =
      a2[r] ^ a3[(r+1)%NROWS] ^ a[(r+2)%NROWS] ^ a[(r+3)%NROWS];
  end

endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_pipe_pkg::*;
#(
  parameter bit LAST = 1'b0
)(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  output logic [BLK_W-1:0] state_o
);

  logic [BLK_W-1:0] subd, shifted, mixed;

  aes_sbox_bank u_sub (.din(state_i), .dout(subd));

  // row r rotated left by r columns: pure wiring
  for (genvar c = 0; c < NCOLS; c++) begin : g_sc
    for (genvar r = 0; r < NROWS; r++) begin : g_sr
      assign shifted[byte_lsb(NROWS*c + r) +: BYTE_W] =
        subd[byte_lsb(NROWS*((c + r) % NCOLS) + r) +: BYTE_W];
    end
  end

  if (LAST) begin : g_nomix
    assign mixed = shifted;
  end else begin : g_mix
    for (genvar c = 0; c < NCOLS; c++) begin : g_col
      aes_col_mix u_mix (
        .col_i(shifted[BLK_W-COL_W*(c+1) +: COL_W]),
        .col_o(mixed[BLK_W-COL_W*(c+1) +: COL_W])
      );
    end
  end

  assign state_o = mixed ^ rkey_i;

endmodule

// File: rtl/aes128_pipe_enc.sv
module aes128_pipe_enc
  import aes_pipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BLK_W-1:0]  plaintext,
  input  logic [KEYS_W-1:0] round_keys,
  output logic              out_valid,
  output logic [BLK_W-1:0]  ciphertext
);

  logic [BLK_W-1:0]  st_q [STAGES];
  logic [BLK_W-1:0]  d_in [STAGES];
  logic [STAGES-1:0] vld_q;
  logic [STAGES-1:0] vld_in;

  assign vld_in  = {vld_q[STAGES-2:0], in_valid};
  assign d_in[0] = plaintext ^ round_keys[0 +: BLK_W];

  for (genvar r = 1; r < STAGES; r++) begin : g_rnd
    aes_round #(.LAST(r == ROUNDS)) u_round (
      .state_i(st_q[r-1]),
      .rkey_i (round_keys[r*BLK_W +: BLK_W]),
      .state_o(d_in[r])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      vld_q <= vld_in;
      for (int i = 0; i < STAGES; i++) begin
        if (vld_in[i]) st_q[i] <= d_in[i];
      end
    end
  end

  assign out_valid  = vld_q[STAGES-1];
  assign ciphertext = st_q[STAGES-1];

endmodule

// File: rtl/aes128_pipe_enc_chk.sv
module aes128_pipe_enc_chk
  import aes_pipe_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [BLK_W-1:0] ciphertext
);

  localparam int CYC_W = $clog2(STAGES + 2) + 1;
  localparam logic [CYC_W-1:0] CYC_MAX = '1;
  localparam logic [CYC_W-1:0] FULL    = CYC_W'(STAGES);

  // edges since reset released, saturating
  logic [CYC_W-1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != CYC_MAX) cyc <= cyc + 1'b1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (cyc >= FULL) |-> (out_valid == $past(in_valid, 11)));

  assert_flush_R4: assert property (@(posedge clk) disable iff (rst)
    (cyc < FULL) |-> !out_valid);

  assert_rst_clear_R4: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ((cyc != '0) && !out_valid) |-> $stable(ciphertext));

  assert_known_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(ciphertext));

endmodule

bind aes128_pipe_enc aes128_pipe_enc_chk chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .ciphertext(ciphertext)
);

// File: tb/aes128_pipe_enc_tb_top.sv
`timescale 1ns/1ps
module aes128_pipe_enc_tb_top;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [127:0]  plaintext = '0;
  logic [1407:0] round_keys = '0;
  logic          out_valid;
  logic [127:0]  ciphertext;

  aes128_pipe_enc dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .plaintext(plaintext),
    .round_keys(round_keys), .out_valid(out_valid), .ciphertext(ciphertext)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit started = 0, finished = 0;
  int outcnt = 0, run = 0, maxrun = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [7:0] sb [256];
  initial begin
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ (p << 1) ^ ((p & 8'h80) != 0 ? 8'h1b : 8'h00);
      q = q ^ (q << 1); q = q ^ (q << 2); q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  end

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    for (int i = 7; i >= 0; i--) begin
      r = (r[7]) ? ((r << 1) ^ 8'h1b) : (r << 1);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [1407:0] expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    logic [1407:0] o;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc, 24'h0};
        rc = fmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int k = 0; k < 11; k++)
      o[128*k +: 128] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
    return o;
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [1407:0] rk);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] k, o;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rk[127-8*i -: 8];
    for (int rd = 1; rd <= 10; rd++) begin
      k = rk[128*rd +: 128];
      for (int i = 0; i < 16; i++) t[(i/4)*4 + i%4] = sb[s[((i/4 + i%4) % 4)*4 + i%4]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          s[4*c+r] = (rd == 10) ? t[4*c+r] :
                     fmul(t[4*c+r], 2) ^ fmul(t[4*c+(r+1)%4], 3) ^ t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ k[127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  // cycle model of the output side
  logic [127:0] cur_exp = '0;
  bit           m_v [11];
  logic [127:0] m_d [11];
  logic [127:0] m_out = '0;
  initial for (int i = 0; i < 11; i++) begin m_v[i] = 0; m_d[i] = '0; end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 11; i++) m_v[i] = 0;
      m_out = '0;
    end else begin
      if (m_v[9]) m_out = m_d[9];
      for (int i = 10; i > 0; i--) begin m_v[i] = m_v[i-1]; m_d[i] = m_d[i-1]; end
      m_v[0] = in_valid;
      m_d[0] = cur_exp;
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(out_valid == m_v[10], "R3 out_valid sequence", 128'(out_valid), 128'(m_v[10]));
      if (m_v[10]) chk(ciphertext == m_out, "R3 streamed ciphertext", ciphertext, m_out);
      else         chk(ciphertext == m_out, "R5 hold while idle", ciphertext, m_out);
      if (out_valid) begin outcnt++; run++; if (run > maxrun) maxrun = run; end
      else run = 0;
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit v, input logic [127:0] pt);
    @(negedge clk);
    in_valid  = v;
    plaintext = pt;
    cur_exp   = ref_enc(pt, round_keys);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0);
  endtask

  task automatic single(input logic [127:0] key, input logic [127:0] pt,
                        input logic [127:0] exp, input string tag);
    round_keys = expand(key);
    drive(1'b1, pt);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (9) @(negedge clk);
    chk(out_valid == 1'b0, "R2 not before edge 11", 128'(out_valid), 128'(0));
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 valid after edge 11", 128'(out_valid), 128'(1));
    chk(ciphertext == exp, tag, ciphertext, exp);
    idle(2);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin : watchdog
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int c0, n;
    logic [127:0] k2;
    void'($urandom(32'h5eed));
    round_keys = expand(128'h000102030405060708090a0b0c0d0e0f);
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R4 reset out_valid", 128'(out_valid), 128'(0));
    chk(ciphertext == '0, "R4 reset ciphertext", ciphertext, '0);
    rst = 1'b0;
    started = 1;

    // R1 full known vector, R6 zero vector, R8 byte order vector
    single(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
           128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 known vector");
    single('0, '0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R6 zero key zero block");
    single(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
           128'h3925841d02dc09fbdc118597196a0b32, "R8 byte order vector");
    // R7 high-bit bytes through doubling and tripling
    single({16{8'h80}}, {16{8'hff}},
           ref_enc({16{8'hff}}, expand({16{8'h80}})), "R7 msb-set bytes");
    single({16{8'hff}}, {16{8'h80}},
           ref_enc({16{8'h80}}, expand({16{8'hff}})), "R7 msb-set bytes swapped");

    // R3 back-to-back burst
    c0 = outcnt; maxrun = 0;
    for (int i = 0; i < 24; i++) drive(1'b1, rnd128());
    idle(14);
    chk(outcnt - c0 == 24, "R3 burst count", 128'(outcnt - c0), 128'(24));
    chk(maxrun == 24, "R3 burst contiguous", 128'(maxrun), 128'(24));

    // R5 holes in the stream
    c0 = outcnt; n = 0;
    for (int i = 0; i < 30; i++) begin
      drive(i % 3 != 0, rnd128());
      if (i % 3 != 0) n++;
    end
    idle(14);
    chk(outcnt - c0 == n, "R5 gapped count", 128'(outcnt - c0), 128'(n));

    // R9 new key schedule after drain
    k2 = rnd128();
    round_keys = expand(k2);
    c0 = outcnt;
    for (int i = 0; i < 10; i++) drive(1'b1, rnd128());
    idle(14);
    chk(outcnt - c0 == 10, "R9 blocks under new key", 128'(outcnt - c0), 128'(10));
    single(k2, 128'h0, ref_enc(128'h0, expand(k2)), "R9 key slice placement");

    // R4 reset in the middle of a burst
    c0 = outcnt;
    for (int i = 0; i < 6; i++) drive(1'b1, rnd128());
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    idle(15);
    chk(outcnt - c0 == 0, "R4 no output after mid-burst reset", 128'(outcnt - c0), 128'(0));
    chk(ciphertext == '0, "R4 ciphertext cleared", ciphertext, '0);

    single(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
           128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 known vector after reset");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule